// File: doc/BRIEF.md
# Address Register Post-Modify Unit

This block keeps four data-memory address pointers for a small signal-processing core and advances them after each indirect access. Every pointer has its own paired stride register, and one shared limit register serves a bounded stepping operation. Each cycle the core presents a pointer select, an operation kind and a two-bit modify mode with a strobe. The block drives the selected pointer's current value, which is the address for the memory access. At the next clock edge it stores the modified pointer. The memory and the data it holds are outside the block.

The block supports four kinds of operation. The first is the usual post-modify step: hold, minus one, plus one, or plus the paired stride. The second is an explicit add of any stride register to any pointer. The third is a bounded step, which moves a pointer by the limit only while the result stays in the low 2 KiB window. Otherwise it moves the pointer by a single unit. The fourth is an instruction-memory indirect read, which accepts only the three simple modes. A write port loads the pointers, the strides and the limit.

Top module: `addr_postmod_unit`

## Requirements
- R1: After reset, all pointers, strides and the limit read as zero, and `illegalReq` is low.
- R2: For opKind 0 (data access), modMode 0 leaves the selected pointer unchanged, 1 subtracts one and 2 adds one. All arithmetic wraps modulo 2^16.
- R3: For opKind 0, modMode 3 adds the selected pointer's own stride register (stride n belongs to pointer n), wrapping modulo 2^16.
- R4: During a strobed operation, `accessAddr` shows the value of the selected pointer from before the modify step. The stored result appears from the next clock edge onward.
- R5: opKind 2 adds the stride selected by `idxSel`, taken as signed 16-bit, to the pointer selected by `regSel`. The two selects are independent, and the result wraps.
- R6: opKind 3 (step down) and opKind 4 (step up) form the 17-bit sum of the pointer and the limit. If that sum is at most 0x7FF, the low 16 bits are stored. Otherwise the pointer is decremented by one (kind 3) or incremented by one (kind 4). The comparison uses the unwrapped sum.
- R7: opKind 1 (instruction-memory read) behaves like kind 0 for modMode 0 to 2. With modMode 3 it raises `illegalReq` in that cycle and changes no pointer.
- R8: When `wrEn` is high, `wrData` is loaded at the next edge into the register given by `wrSel`: 0 to 3 select pointers, 4 to 7 select strides 0 to 3, and 8 selects the limit. A strobed operation in the same cycle is dropped.
- R9: opKind values 5 to 7 raise `illegalReq` and change no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register load strobe |
| wrSel | input | 4 | Load target: 0-3 pointer, 4-7 stride, 8 limit |
| wrData | input | 16 | Load value |
| opStrobe | input | 1 | Operation request |
| opKind | input | 3 | 0 data, 1 instr read, 2 stride add, 3 step down, 4 step up |
| regSel | input | 2 | Pointer select |
| idxSel | input | 2 | Stride select for opKind 2 |
| modMode | input | 2 | Post-modify mode for kinds 0 and 1 |
| accessAddr | output | 16 | Selected pointer before modification |
| illegalReq | output | 1 | Unsupported request in this cycle |

## Verification
On every cycle, assertions check four things: decrements and increments land one away from the old pointer, idle cycles and rejected requests leave all pointers frozen, bounded steps end either inside the window or one unit from the start, and loads land where `wrSel` points. The bench's scenarios are needed to show the exact stride sums, the signed wrap of the stride add, and the threshold cases of the bounded step, including a sum that wraps past 2^16 but must still count as out of window. Write priority over a coincident operation also needs a scenario.

// File: rtl/adrmod_pkg.sv
package adrmod_pkg;
  localparam int ADDR_W     = 16;
  localparam int NUM_AREG   = 4;
  localparam int AREG_SEL_W = $clog2(NUM_AREG);
  localparam int WR_SEL_W   = $clog2(2 * NUM_AREG + 1);

  typedef enum logic [2:0] {
    KIND_DMEM   = 3'd0,
    KIND_IMEM   = 3'd1,
    KIND_IDXADD = 3'd2,
    KIND_BDEC   = 3'd3,
    KIND_BINC   = 3'd4
  } opKind_e;

  typedef enum logic [2:0] {
    ADD_ZERO,
    ADD_M1,
    ADD_P1,
    ADD_INDEX,
    ADD_BND_DEC,
    ADD_BND_INC
  } addSel_e;

  typedef struct packed {
    logic                  updEn;
    logic [AREG_SEL_W-1:0] tgt;
    logic [AREG_SEL_W-1:0] idxPick;
    addSel_e               addSel;
    logic                  illegal;
  } modCtl_t;
endpackage

// File: rtl/adrmod_ctrl.sv
module adrmod_ctrl
  import adrmod_pkg::*;
(
  input  logic                  wrEn,
  input  logic                  opStrobe,
  input  logic [2:0]            opKind,
  input  logic [AREG_SEL_W-1:0] regSel,
  input  logic [AREG_SEL_W-1:0] idxSel,
  input  logic [1:0]            modMode,
  output modCtl_t               ctl
);
  opKind_e kind;
  assign kind = opKind_e'(opKind);

  always_comb begin
    ctl.updEn   = 1'b0;
    ctl.tgt     = regSel;
    ctl.idxPick = regSel;
    ctl.addSel  = ADD_ZERO;
    ctl.illegal = 1'b0;
    if (opStrobe && !wrEn) begin
      case (kind)
        KIND_DMEM, KIND_IMEM: begin
          if (kind == KIND_IMEM && modMode == 2'd3) begin
            ctl.illegal = 1'b1;
          end else begin
            ctl.updEn = 1'b1;
            case (modMode)
              2'd0:    ctl.addSel = ADD_ZERO;
              2'd1:    ctl.addSel = ADD_M1;
              2'd2:    ctl.addSel = ADD_P1;
              default: ctl.addSel = ADD_INDEX;
            endcase
          end
        end
        KIND_IDXADD: begin
          ctl.updEn   = 1'b1;
          ctl.addSel  = ADD_INDEX;
          ctl.idxPick = idxSel;
        end
        KIND_BDEC: begin
          ctl.updEn  = 1'b1;
          ctl.addSel = ADD_BND_DEC;
        end
        KIND_BINC: begin
          ctl.updEn  = 1'b1;
          ctl.addSel = ADD_BND_INC;
        end
        default: ctl.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/adrmod_datapath.sv
module adrmod_datapath
  import adrmod_pkg::*;
#(
  parameter int          BOUND_MAX = 'h7FF
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [WR_SEL_W-1:0] wrSel,
  input  logic [ADDR_W-1:0]   wrData,
  input  modCtl_t             ctl,
  output logic [ADDR_W-1:0]   curAddr
);
  localparam logic [ADDR_W:0] BOUND_LIM = (ADDR_W+1)'(BOUND_MAX);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [NUM_AREG-1:0][ADDR_W-1:0] addrQ;
  logic [NUM_AREG-1:0][ADDR_W-1:0] idxQ;
  logic [ADDR_W-1:0]               limitQ;
  logic [ADDR_W-1:0]               idxVal;
  logic [ADDR_W:0]                 bndSum;
  logic [ADDR_W-1:0]               nxtAddr;
  logic [WR_SEL_W-1:0]             idxOff;

  assign curAddr = addrQ[ctl.tgt];
  assign idxVal  = idxQ[ctl.idxPick];
  assign bndSum  = {1'b0, curAddr} + {1'b0, limitQ};
  assign idxOff  = wrSel - WR_SEL_W'(NUM_AREG);

  always_comb begin
    case (ctl.addSel)
      ADD_M1:      nxtAddr = curAddr - ONE;
      ADD_P1:      nxtAddr = curAddr + ONE;
      ADD_INDEX:   nxtAddr = curAddr + idxVal;
      ADD_BND_DEC: nxtAddr = (bndSum <= BOUND_LIM) ? bndSum[ADDR_W-1:0] : curAddr - ONE;
      ADD_BND_INC: nxtAddr = (bndSum <= BOUND_LIM) ? bndSum[ADDR_W-1:0] : curAddr + ONE;
      default:     nxtAddr = curAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      idxQ   <= '0;
      limitQ <= '0;
    end else if (wrEn) begin
      if (wrSel < WR_SEL_W'(NUM_AREG))
        addrQ[wrSel[AREG_SEL_W-1:0]] <= wrData;
      else if (wrSel < WR_SEL_W'(2 * NUM_AREG))
        idxQ[idxOff[AREG_SEL_W-1:0]] <= wrData;
      else if (wrSel == WR_SEL_W'(2 * NUM_AREG))
        limitQ <= wrData;
    end else if (ctl.updEn) begin
      addrQ[ctl.tgt] <= nxtAddr;
    end
  end

  // R2: a decrement step lands exactly one below the old pointer
  assert_dec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.updEn && ctl.addSel == ADD_M1) |=> addrQ[$past(ctl.tgt)] == $past(curAddr) - ONE);

  // R2: an increment step lands exactly one above the old pointer
  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.updEn && ctl.addSel == ADD_P1) |=> addrQ[$past(ctl.tgt)] == $past(curAddr) + ONE);

  // R2: with no update and no load, every pointer holds
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.updEn && !wrEn) |=> $stable(addrQ));

  // R7 / R9: a rejected request freezes all pointers
  assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.illegal |=> $stable(addrQ));

  // R6: a bounded step ends inside the window or one unit from the start
  assert_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.updEn && (ctl.addSel == ADD_BND_DEC || ctl.addSel == ADD_BND_INC)) |=>
      ((ADDR_W+1)'(addrQ[$past(ctl.tgt)]) <= BOUND_LIM) ||
      (addrQ[$past(ctl.tgt)] == $past(curAddr) + ONE) ||
      (addrQ[$past(ctl.tgt)] == $past(curAddr) - ONE));

  // R8: a pointer load lands in the register wrSel names
  assert_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel < WR_SEL_W'(NUM_AREG)) |=>
      addrQ[$past(wrSel[AREG_SEL_W-1:0])] == $past(wrData));
endmodule

// File: rtl/addr_postmod_unit.sv
module addr_postmod_unit
  import adrmod_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [WR_SEL_W-1:0]   wrSel,
  input  logic [ADDR_W-1:0]     wrData,
  input  logic                  opStrobe,
  input  logic [2:0]            opKind,
  input  logic [AREG_SEL_W-1:0] regSel,
  input  logic [AREG_SEL_W-1:0] idxSel,
  input  logic [1:0]            modMode,
  output logic [ADDR_W-1:0]     accessAddr,
  output logic                  illegalReq
);
  modCtl_t ctl;

  adrmod_ctrl u_ctrl (
    .wrEn    (wrEn),
    .opStrobe(opStrobe),
    .opKind  (opKind),
    .regSel  (regSel),
    .idxSel  (idxSel),
    .modMode (modMode),
    .ctl     (ctl)
  );

  adrmod_datapath #(.BOUND_MAX('h7FF)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .ctl    (ctl),
    .curAddr(accessAddr)
  );

  assign illegalReq = ctl.illegal;
endmodule

// File: tb/addr_postmod_unit_test.sv
module addr_postmod_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic        opStrobe = 1'b0;
  logic [2:0]  opKind = '0;
  logic [1:0]  regSel = '0;
  logic [1:0]  idxSel = '0;
  logic [1:0]  modMode = '0;
  logic [15:0] accessAddr;
  logic        illegalReq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  addr_postmod_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .opStrobe(opStrobe), .opKind(opKind), .regSel(regSel), .idxSel(idxSel),
    .modMode(modMode), .accessAddr(accessAddr), .illegalReq(illegalReq)
  );

  // fields: kind(3) sel(2) idx(2) mode(2) expPre(16) expPost(16) expIll(1)
  localparam int NV = 18;
  localparam logic [41:0] VEC [NV] = '{
    {3'd0, 2'd0, 2'd0, 2'd0, 16'h0010, 16'h0010, 1'b0}, // R2 hold
    {3'd0, 2'd0, 2'd0, 2'd1, 16'h0010, 16'h000F, 1'b0}, // R2 dec
    {3'd0, 2'd0, 2'd0, 2'd2, 16'h000F, 16'h0010, 1'b0}, // R2 inc
    {3'd0, 2'd1, 2'd0, 2'd1, 16'h0000, 16'hFFFF, 1'b0}, // R2 wrap down
    {3'd0, 2'd2, 2'd0, 2'd2, 16'hFFFF, 16'h0000, 1'b0}, // R2 wrap up
    {3'd0, 2'd0, 2'd0, 2'd3, 16'h0010, 16'h0015, 1'b0}, // R3 stride
    {3'd0, 2'd1, 2'd0, 2'd3, 16'hFFFF, 16'hFFFD, 1'b0}, // R3 neg stride
    {3'd2, 2'd2, 2'd3, 2'd0, 16'h0000, 16'h8000, 1'b0}, // R5 cross select
    {3'd2, 2'd0, 2'd1, 2'd0, 16'h0015, 16'h0013, 1'b0}, // R5 signed
    {3'd4, 2'd3, 2'd0, 2'd0, 16'h07F0, 16'h07FF, 1'b0}, // R6 at limit
    {3'd4, 2'd3, 2'd0, 2'd0, 16'h07FF, 16'h0800, 1'b0}, // R6 over up
    {3'd3, 2'd3, 2'd0, 2'd0, 16'h0800, 16'h07FF, 1'b0}, // R6 over down
    {3'd3, 2'd0, 2'd0, 2'd0, 16'h0013, 16'h0022, 1'b0}, // R6 inside
    {3'd1, 2'd0, 2'd0, 2'd2, 16'h0022, 16'h0023, 1'b0}, // R7 imem inc
    {3'd1, 2'd0, 2'd0, 2'd3, 16'h0023, 16'h0023, 1'b1}, // R7 illegal
    {3'd5, 2'd0, 2'd0, 2'd0, 16'h0023, 16'h0023, 1'b1}, // R9 reserved
    {3'd4, 2'd2, 2'd0, 2'd0, 16'h8000, 16'h8001, 1'b0}, // R6 high ptr
    {3'd1, 2'd1, 2'd0, 2'd1, 16'hFFFD, 16'hFFFC, 1'b0}  // R7 imem dec
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadReg(input logic [3:0] sel, input logic [15:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readPtr(input logic [1:0] sel, input string req, input logic [15:0] exp);
    @(negedge clk);
    opStrobe = 1'b0; regSel = sel;
    #1 check(req, accessAddr, exp);
  endtask

  task automatic runOp(input logic [2:0] k, input logic [1:0] s, input logic [1:0] ix,
                       input logic [1:0] m, output logic [15:0] pre, output logic ill);
    @(negedge clk);
    opStrobe = 1'b1; opKind = k; regSel = s; idxSel = ix; modMode = m;
    #1 pre = accessAddr; ill = illegalReq;
    @(negedge clk);
    opStrobe = 1'b0;
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] pre;
    logic        ill;
    repeat (2) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) readPtr(2'(i), "R1", 16'h0000);
    nChecks++;
    if (illegalReq !== 1'b0) begin nFails++; $display("FAIL R1: actual %b expected 0", illegalReq); end
    rstN = 1'b1;
    // R1: strides and limit zero -> mode 3 and bounded step leave 0 behaviour
    runOp(3'd0, 2'd0, 2'd0, 2'd3, pre, ill);
    readPtr(2'd0, "R1 stride zero", 16'h0000);
    runOp(3'd4, 2'd1, 2'd0, 2'd0, pre, ill);
    readPtr(2'd1, "R1 limit zero", 16'h0000);

    // R8 preload
    loadReg(4'd0, 16'h0010); loadReg(4'd1, 16'h0000);
    loadReg(4'd2, 16'hFFFF); loadReg(4'd3, 16'h07F0);
    loadReg(4'd4, 16'h0005); loadReg(4'd5, 16'hFFFE);
    loadReg(4'd6, 16'h0100); loadReg(4'd7, 16'h8000);
    loadReg(4'd8, 16'h000F);
    readPtr(2'd3, "R8 load", 16'h07F0);

    for (int v = 0; v < NV; v++) begin
      logic [41:0] e;
      e = VEC[v];
      runOp(e[41:39], e[38:37], e[36:35], e[34:33], pre, ill);
      check("R4 pre-modify", pre, e[32:17]);
      check("R7/R9 illegal flag", {15'd0, ill}, {15'd0, e[0]});
      readPtr(e[38:37], "R2-7 post value", e[16:1]);
    end

    // R6 unwrapped compare: FFF8 + 000F = 0x10007 > 0x7FF -> increment
    loadReg(4'd0, 16'hFFF8);
    runOp(3'd4, 2'd0, 2'd0, 2'd0, pre, ill);
    readPtr(2'd0, "R6 unwrapped", 16'hFFF9);

    // R8 write priority: op in same cycle dropped
    @(negedge clk);
    wrEn = 1'b1; wrSel = 4'd1; wrData = 16'h1234;
    opStrobe = 1'b1; opKind = 3'd0; regSel = 2'd0; modMode = 2'd2;
    @(negedge clk);
    wrEn = 1'b0; opStrobe = 1'b0;
    readPtr(2'd0, "R8 op dropped", 16'hFFF9);
    readPtr(2'd1, "R8 write wins", 16'h1234);

    // R9 reserved kind 7 leaves pointer
    runOp(3'd7, 2'd1, 2'd0, 2'd2, pre, ill);
    check("R9 flag", {15'd0, ill}, 16'h0001);
    readPtr(2'd1, "R9 no change", 16'h1234);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule